// File: doc/BRIEF.md
# Sparsified hit capture buffer

This block captures the binary hit outputs of one pixel row and keeps only the parts of the row that carry information. On each bunch-crossing strobe it latches the 42-pixel hit vector. It then walks through the vector in seven 6-pixel segments, one per clock cycle. Each segment with at least one hit becomes a record made of a timestamp, the segment index and the 6-bit sub-pattern. Records go into a bank of 19 slots, and each slot is written at most once until the bank is cleared.

When a non-empty segment finds the bank full, that record is lost and a sticky overflow flag is raised. Readout takes place between acquisition periods. A valid/ready port streams the stored records in the order they were written, marks the final one, and never presents an unwritten slot. A test override makes every segment look fully hit, which fills the bank with false records. A clear input empties the bank, drops the flags and restarts the timestamp.

Top module: `hitseg_capture`

## Requirements
- R1: After reset, rd_valid, overflow and strobe_collision are 0, and the bank holds no records.
- R2: A strobe taken while acq_en is 1 and no scan is running starts a scan of 7 cycles. Segments are examined in index order 0 to 6, and each segment with a nonzero sub-pattern is appended to the bank. All-zero segments use no slot.
- R3: A nonzero segment that finds all 19 slots occupied is dropped, and overflow goes to 1 and stays at 1 until clear or reset.
- R4: A record is 22 bits: timestamp in bits 21:9, segment index (0 to 6) in bits 8:6, and sub-pattern in bits 5:0, where pattern bit k is the hit of pixel 6*index+k.
- R5: The timestamp of a record equals the number of strobes accepted since the last clear or reset, counted before the current strobe. The first accepted strobe therefore gives 0.
- R6: A strobe that arrives while a scan is running is ignored: it stores no record and does not advance the timestamp. It sets the sticky strobe_collision flag.
- R7: A strobe that arrives while acq_en is 0 is ignored: it stores nothing and does not advance the timestamp.
- R8: A strobe taken with force_hits at 1 stores all 7 segments, each with pattern 6'b111111, whatever hits_in holds.
- R9: Records are presented only while acq_en is 0 and no scan is running. They come out in write order, one per beat in which rd_valid and rd_ready are both 1. rd_last is 1 on the final stored record, and rd_valid falls once that record has been accepted.
- R10: While rd_valid is 1 and rd_ready is 0, rd_valid stays 1 and rd_data holds its value.
- R11: A clear pulse empties the bank, clears overflow and strobe_collision, and sets the timestamp back to 0.
- R12: A stored record is never overwritten. After an overflow, the first 19 records read back exactly as they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Empties the bank, drops the flags, restarts the timestamp |
| acq_en | input | 1 | 1: acquisition (strobes accepted); 0: readout phase |
| bx_strobe | input | 1 | One-cycle bunch-crossing strobe |
| hits_in | input | 42 | Binary pixel hits; bit p is pixel p |
| force_hits | input | 1 | Test override, sampled with the strobe |
| rd_valid | output | 1 | A record is on rd_data |
| rd_ready | input | 1 | Consumer accepts the record |
| rd_data | output | 22 | Record {timestamp, segment index, pattern} |
| rd_last | output | 1 | Marks the final stored record |
| overflow | output | 1 | Sticky: a record was dropped because the bank was full |
| strobe_collision | output | 1 | Sticky: a strobe arrived during a scan |

## Verification
Most internal faults only show up at the readout port, and only when the bank is drained after acquisition. A wrong allocation pointer shows as a missing, repeated or reordered record. A faulty segment counter or selector shows as a wrong index or pattern field. A timestamp fault shows as a shifted field on every later record. The flags are the exception: overflow and strobe_collision become visible within nine cycles of the strobe that should set them. For this reason the bench sweeps many row patterns, drains after every small group of strobes, compares each field against an arithmetic model, and checks the flags after every scan.

// File: rtl/hitseg_pkg.sv
package hitseg_pkg;
  localparam int unsigned DEF_PIXELS = 42;
  localparam int unsigned DEF_SEG_W  = 6;
  localparam int unsigned DEF_SLOTS  = 19;
  localparam int unsigned DEF_TS_W   = 13;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/hitseg_scanner.sv
module hitseg_scanner
  import hitseg_pkg::*;
#(
  parameter int unsigned PIXELS = DEF_PIXELS,
  parameter int unsigned SEG_W  = DEF_SEG_W,
  parameter int unsigned TS_W   = DEF_TS_W,
  localparam int unsigned NSEG  = PIXELS / SEG_W,
  localparam int unsigned IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              acq_en,
  input  logic              bx_strobe,
  input  logic [PIXELS-1:0] hits_in,
  input  logic              force_hits,
  output logic              busy,
  output logic              seg_valid,
  output logic [IDX_W-1:0]  seg_idx,
  output logic [SEG_W-1:0]  seg_bits,
  output logic [TS_W-1:0]   seg_ts,
  output logic              collision
);

  scan_state_e       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TS_W-1:0]   ts_q;
  logic [TS_W-1:0]   rec_ts_q;
  logic [PIXELS-1:0] row_q;
  logic              force_q;
  logic              collision_q;
  logic              take;

  logic [SEG_W-1:0]  seg_arr [NSEG];
  logic [SEG_W-1:0]  pick;

  assign take = bx_strobe && acq_en && (state_q == SCAN_IDLE);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state_q     <= SCAN_IDLE;
      idx_q       <= '0;
      ts_q        <= '0;
      rec_ts_q    <= '0;
      row_q       <= '0;
      force_q     <= 1'b0;
      collision_q <= 1'b0;
    end else begin
      if (bx_strobe && acq_en && (state_q == SCAN_RUN)) begin
        collision_q <= 1'b1;
      end
      if (take) begin
        row_q    <= hits_in;
        force_q  <= force_hits;
        rec_ts_q <= ts_q;
        ts_q     <= ts_q + TS_W'(1);
        idx_q    <= '0;
        state_q  <= SCAN_RUN;
      end else if (state_q == SCAN_RUN) begin
        if (idx_q == IDX_W'(NSEG - 1)) begin
          idx_q   <= '0;
          state_q <= SCAN_IDLE;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign seg_arr[g] = row_q[g*SEG_W +: SEG_W];
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (idx_q == IDX_W'(i)) pick = seg_arr[i];
    end
  end

  assign busy      = (state_q == SCAN_RUN);
  assign seg_bits  = force_q ? {SEG_W{1'b1}} : pick;
  assign seg_valid = busy && (|seg_bits);
  assign seg_idx   = idx_q;
  assign seg_ts    = rec_ts_q;
  assign collision = collision_q;

endmodule

// File: rtl/hitseg_store.sv
module hitseg_store
  import hitseg_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS,
  parameter int unsigned REC_W = 22,
  localparam int unsigned CW   = $clog2(SLOTS + 1),
  localparam int unsigned AW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             wr_req,
  input  logic [REC_W-1:0] wr_rec,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [REC_W-1:0] rd_rec,
  output logic [CW-1:0]    count,
  output logic             overflow,
  output logic             wr_en
);

  logic [REC_W-1:0] mem [SLOTS];
  logic [REC_W-1:0] rd_q;
  logic [CW-1:0]    count_q;
  logic             ovf_q;
  logic             full;

  assign full  = (count_q == CW'(SLOTS));
  assign wr_en = wr_req && !full;

  // Plain array: one write port at the fill pointer, one registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[count_q[AW-1:0]] <= wr_rec;
    if (rd_en) rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (wr_req) begin
      if (full) ovf_q   <= 1'b1;
      else      count_q <= count_q + CW'(1);
    end
  end

  assign rd_rec   = rd_q;
  assign count    = count_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/hitseg_readout.sv
module hitseg_readout
  import hitseg_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS,
  localparam int unsigned CW   = $clog2(SLOTS + 1),
  localparam int unsigned AW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          enable,
  input  logic [CW-1:0] count,
  input  logic          rd_ready,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic          rd_last
);

  logic [CW-1:0] ptr_q;
  logic          valid_q;
  logic          last_q;
  logic          more;

  assign more    = (ptr_q < count);
  assign rd_en   = enable && more && (!valid_q || rd_ready);
  assign rd_addr = ptr_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ptr_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (rd_en) begin
      valid_q <= 1'b1;
      last_q  <= ((ptr_q + CW'(1)) == count);
      ptr_q   <= ptr_q + CW'(1);
    end else if (rd_ready) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end
  end

  assign rd_valid = valid_q;
  assign rd_last  = last_q;

endmodule

// File: rtl/hitseg_capture.sv
module hitseg_capture
  import hitseg_pkg::*;
#(
  parameter int unsigned PIXELS = DEF_PIXELS,
  parameter int unsigned SEG_W  = DEF_SEG_W,
  parameter int unsigned SLOTS  = DEF_SLOTS,
  parameter int unsigned TS_W   = DEF_TS_W,
  localparam int unsigned NSEG  = PIXELS / SEG_W,
  localparam int unsigned IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int unsigned REC_W = TS_W + IDX_W + SEG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              acq_en,
  input  logic              bx_strobe,
  input  logic [PIXELS-1:0] hits_in,
  input  logic              force_hits,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [REC_W-1:0]  rd_data,
  output logic              rd_last,
  output logic              overflow,
  output logic              strobe_collision
);

  localparam int unsigned CW = $clog2(SLOTS + 1);
  localparam int unsigned AW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic             scan_busy;
  logic             seg_valid;
  logic [IDX_W-1:0] seg_idx;
  logic [SEG_W-1:0] seg_bits;
  logic [TS_W-1:0]  seg_ts;
  logic             wr_en;
  logic [CW-1:0]    bank_count;
  logic             rd_en;
  logic [AW-1:0]    rd_addr;

  hitseg_scanner #(
    .PIXELS (PIXELS),
    .SEG_W  (SEG_W),
    .TS_W   (TS_W)
  ) u_scan (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear),
    .acq_en     (acq_en),
    .bx_strobe  (bx_strobe),
    .hits_in    (hits_in),
    .force_hits (force_hits),
    .busy       (scan_busy),
    .seg_valid  (seg_valid),
    .seg_idx    (seg_idx),
    .seg_bits   (seg_bits),
    .seg_ts     (seg_ts),
    .collision  (strobe_collision)
  );

  hitseg_store #(
    .SLOTS (SLOTS),
    .REC_W (REC_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .wr_req   (seg_valid),
    .wr_rec   ({seg_ts, seg_idx, seg_bits}),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_rec   (rd_data),
    .count    (bank_count),
    .overflow (overflow),
    .wr_en    (wr_en)
  );

  hitseg_readout #(
    .SLOTS (SLOTS)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .enable   (!acq_en && !scan_busy),
    .count    (bank_count),
    .rd_ready (rd_ready),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_last  (rd_last)
  );

endmodule

// File: rtl/hitseg_capture_chk.sv
module hitseg_capture_chk #(
  parameter int unsigned SLOTS = 19,
  parameter int unsigned NSEG  = 7,
  parameter int unsigned CW    = 5,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned REC_W = 22
) (
  input logic             clk,
  input logic             rst,
  input logic             clear,
  input logic             acq_en,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [REC_W-1:0] rd_data,
  input logic             overflow,
  input logic             strobe_collision,
  input logic             busy,
  input logic [IDX_W-1:0] seg_idx,
  input logic             wr_en,
  input logic [CW-1:0]    count
);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready && !clear) |=> (rd_valid && $stable(rd_data)));

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (overflow && !clear) |=> overflow);

  assert_overflow_when_full_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> ($past(count) == CW'(SLOTS)));

  assert_collision_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe_collision && !clear) |=> strobe_collision);

  assert_write_in_scan_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

  assert_no_write_full_R12: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (count < CW'(SLOTS)));

  assert_seg_range_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (seg_idx < IDX_W'(NSEG)));

  assert_read_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> !$past(acq_en));

endmodule

bind hitseg_capture hitseg_capture_chk #(
  .SLOTS (SLOTS),
  .NSEG  (NSEG),
  .CW    (CW),
  .IDX_W (IDX_W),
  .REC_W (REC_W)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .clear            (clear),
  .acq_en           (acq_en),
  .rd_valid         (rd_valid),
  .rd_ready         (rd_ready),
  .rd_data          (rd_data),
  .overflow         (overflow),
  .strobe_collision (strobe_collision),
  .busy             (scan_busy),
  .seg_idx          (seg_idx),
  .wr_en            (wr_en),
  .count            (bank_count)
);

// File: tb/hitseg_capture_tb.sv
module hitseg_capture_tb;
  localparam int PIX = 42;
  localparam int SW  = 6;
  localparam int NS  = 7;
  localparam int SL  = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clear = 1'b0;
  logic          acq_en = 1'b1;
  logic          bx_strobe = 1'b0;
  logic [PIX-1:0] hits_in = '0;
  logic          force_hits = 1'b0;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [21:0]   rd_data;
  logic          rd_last;
  logic          overflow;
  logic          strobe_collision;

  always #5 clk = ~clk;

  hitseg_capture u_dut (
    .clk (clk), .rst (rst), .clear (clear), .acq_en (acq_en),
    .bx_strobe (bx_strobe), .hits_in (hits_in), .force_hits (force_hits),
    .rd_valid (rd_valid), .rd_ready (rd_ready), .rd_data (rd_data),
    .rd_last (rd_last), .overflow (overflow), .strobe_collision (strobe_collision)
  );

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  logic [21:0] m_rec [SL];
  int m_cnt = 0;
  int m_ts  = 0;
  bit m_ovf = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] want);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, want);
    end
  endtask

  task automatic model_strobe(input logic [PIX-1:0] h, input bit f);
    for (int s = 0; s < NS; s++) begin
      logic [5:0] seg;
      seg = f ? 6'h3f : h[s*SW +: SW];
      if (seg != 0) begin
        if (m_cnt < SL) begin
          m_rec[m_cnt] = {13'(m_ts), 3'(s), seg};
          m_cnt++;
        end else m_ovf = 1;
      end
    end
    m_ts++;
  endtask

  task automatic strobe(input logic [PIX-1:0] h, input bit f);
    @(negedge clk);
    hits_in = h; force_hits = f; bx_strobe = 1'b1;
    if (acq_en) model_strobe(h, f);
    @(negedge clk);
    bx_strobe = 1'b0; hits_in = '0; force_hits = 1'b0;
    repeat (8) @(negedge clk);
    chk(overflow == m_ovf, "R3 overflow flag", overflow, m_ovf);
  endtask

  task automatic clr();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    m_cnt = 0; m_ts = 0; m_ovf = 0;
    chk(overflow == 0, "R11 overflow cleared", overflow, 0);
    chk(strobe_collision == 0, "R11 collision cleared", strobe_collision, 0);
    chk(rd_valid == 0, "R11 bank empty", rd_valid, 0);
  endtask

  // mode 0: always ready, 1: every second cycle, 2: every third cycle
  task automatic drain(input int mode, input string tag);
    int got = 0;
    int cyc = 0;
    bit stalled = 0;
    logic [21:0] held = '0;
    @(negedge clk); acq_en = 1'b0;
    while (got < m_cnt && cyc < 400) begin
      @(negedge clk); cyc++;
      if (stalled)
        chk(rd_valid && rd_data == held, "R10 stall hold", rd_data, held);
      rd_ready = (mode == 0) || (mode == 1 && cyc % 2 == 0) || (mode == 2 && cyc % 3 == 0);
      if (rd_valid && rd_ready) begin
        chk(rd_data[21:9] == m_rec[got][21:9], "R5 timestamp", rd_data[21:9], m_rec[got][21:9]);
        chk(rd_data[8:0] == m_rec[got][8:0], tag, rd_data[8:0], m_rec[got][8:0]);
        chk(rd_last == (got == m_cnt - 1), "R9 last flag", rd_last, (got == m_cnt - 1));
        got++; stalled = 0;
      end else if (rd_valid) begin
        held = rd_data; stalled = 1;
      end else stalled = 0;
    end
    chk(got == m_cnt, "R9 record count", got, m_cnt);
    @(negedge clk); rd_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(rd_valid == 0, "R9 no extra record", rd_valid, 0);
    rd_ready = 1'b0; acq_en = 1'b1;
  endtask

  function automatic logic [PIX-1:0] mkpat(input int k);
    logic [PIX-1:0] p = '0;
    for (int s = 0; s < NS; s++) begin
      int v = (k * (2*s + 5) + s * 13) % 64;
      if ((k + s) % 3 == 0) v = 0;
      p[s*SW +: SW] = 6'(v);
    end
    return p;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    chk(overflow == 0, "R1 overflow", overflow, 0);
    chk(strobe_collision == 0, "R1 collision", strobe_collision, 0);
    drain(0, "R1 empty");

    // R2 R4: every single pixel on its own
    for (int p = 0; p < PIX; p++) begin
      clr();
      strobe(PIX'(1) << p, 1'b0);
      drain(p % 3, "R4 single pixel");
    end

    // R2: mixed patterns, several strobes per group, varied backpressure
    for (int g = 0; g < 16; g++) begin
      clr();
      for (int j = 0; j < 4; j++) strobe(mkpat(g*4 + j), 1'b0);
      drain(g % 3, "R2 sparse pattern");
    end

    // R8: override with empty row
    clr();
    strobe('0, 1'b1);
    chk(m_cnt == 7, "R8 model count", m_cnt, 7);
    drain(1, "R8 forced hits");

    // R3 R12: overflow keeps the first 19 records
    clr();
    for (int j = 0; j < 4; j++) strobe({PIX{1'b1}}, 1'b0);
    chk(overflow == 1, "R3 overflow set", overflow, 1);
    drain(2, "R12 write once");
    chk(overflow == 1, "R3 overflow sticky", overflow, 1);

    // R11: clear after overflow, timestamp restarts
    clr();
    strobe(42'h3 << 12, 1'b0);
    drain(0, "R11 after clear");

    // R6: strobe during a scan
    clr();
    @(negedge clk);
    hits_in = 42'h1; bx_strobe = 1'b1;
    model_strobe(42'h1, 1'b0);
    @(negedge clk); bx_strobe = 1'b0; hits_in = '0;
    @(negedge clk); hits_in = {PIX{1'b1}}; bx_strobe = 1'b1;
    @(negedge clk); bx_strobe = 1'b0; hits_in = '0;
    repeat (8) @(negedge clk);
    chk(strobe_collision == 1, "R6 collision flag", strobe_collision, 1);
    strobe(42'h1 << 41, 1'b0);
    drain(0, "R6 ignored strobe");

    // R7: strobe with acquisition off
    clr();
    acq_en = 1'b0;
    strobe({PIX{1'b1}}, 1'b0);
    chk(rd_valid == 0, "R7 nothing stored", rd_valid, 0);
    acq_en = 1'b1;
    strobe(42'h20, 1'b0);
    drain(1, "R7 ignored strobe");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule